// File: doc/BRIEF.md
# Programmable Interlaced Video Sync Generator

This block produces the raster timing for a standard-definition television output. It emits horizontal sync, vertical sync, a color-burst gate, an active-video window and a line-match interrupt. It also reports the current half-line position and the field parity. All timing runs off a quarter-pixel clock enable. A line's length is counted in quarter pixels, and the vertical position is counted in half-lines. Because a line advances the vertical position by two half-lines, an odd number of half-lines per field makes the parity alternate from field to field, which gives interlace. An even number gives progressive scan.

Software programs the block through a word-wide register write port. The line, pulse, field, leap and control settings go into a live bank. That bank is copied into a working shadow only when a field wraps, so a mid-frame reprogramming never tears a field. The horizontal window, the vertical windows and the interrupt line act at once.

For PAL-style timing, lines inside the vertical sync interval can take one of two alternate lengths. A 5-bit pattern chooses between them, one pattern bit per sync line.

Top module: `vidsync_timer`

## Requirements
- R1: Each line lasts (line period + 1) quarter-pixel enables outside vertical sync. The line period is register 1 bits [11:0], and the pixel index is the quarter-pixel count divided by 4.
- R2: At each line end the half-line counter steps by 2. If the result exceeds the field length F (register 3 bits [9:0]), it wraps to the result minus (F+1), or to 0 if that value is still above F. `field_o` equals bit 0 of the counter.
- R3: `hsync_o` is high for pixels 0 up to and including the hsync width (register 2 bits [7:0]). When serration is on (register 0 bit 2) and vertical sync is active, it is inverted instead.
- R4: `vsync_o` is high while the half-line counter is at or below the vsync width (register 3 bits [19:16]).
- R5: `burst_o` is high for pixels from burst start (register 2 bits [25:16]) through burst start plus burst width (bits [15:8]). It also requires the half-line to lie in [start, end), where register 7 holds start in bits [9:0] and end in bits [25:16].
- R6: `active_o` is high when the pixel lies in [start, end) of register 5 and the half-line lies in [start, end) of register 6. Both registers use the same field layout as register 7.
- R7: `line_irq_o` pulses for one clock after a line end that moves the half-line counter onto the interrupt line (register 8 bits [9:0]). The interrupt line resets to 0x3FF.
- R8: Lines that start inside vertical sync use leap length A (register 4 bits [11:0]) or B (bits [23:12]), chosen by pattern bit k (bits [28:24]): 0 selects A, 1 selects B. k advances once per sync line, wraps after 4 and returns to 0 when a field wraps.
- R9: Registers 0 to 4 take effect only when the half-line counter wraps. Registers 5 to 8 take effect on the cycle after the write.
- R10: A pixel type of 0 (register 0 bits [1:0]) forces `hsync_o`, `vsync_o`, `burst_o` and `active_o` low while the counters keep running.
- R11: After reset all strobes are low, the interrupt is low, the half-line is 0 and every timing register is 0.
- R12: While `qpix_en` is low, the counters and every strobe hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qpix_en | input | 1 | Quarter-pixel advance enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync (serrated during vsync when enabled) |
| vsync_o | output | 1 | Vertical sync |
| burst_o | output | 1 | Color-burst gate |
| active_o | output | 1 | Active-video window |
| line_irq_o | output | 1 | One-clock line-match interrupt |
| half_line_o | output | 10 | Current half-line counter |
| field_o | output | 1 | Field parity |

## Verification
The assertions assume that no register write lands in the same cycle as a field wrap. They also assume that writes to the line and leap lengths reach the counter only through the shadow copy, so a line's length is fixed while the line runs. The stimulus keeps within these assumptions by issuing every register write in a cycle where `qpix_en` is low, which means no line end or wrap can happen on that edge. Configurations are chosen so that vertical sync spans more than five lines, which forces the leap index to wrap. A field length with an odd half-line count is used to exercise both parities, and an interrupt line is placed so that it is hit in only one of the two fields.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    localparam int QW     = 12;   // quarter-pixel counter width
    localparam int VW     = 10;   // half-line counter width
    localparam int PW     = 10;   // pixel coordinate width
    localparam int HSW_W  = 8;    // hsync width field
    localparam int BUW_W  = 8;    // burst width field
    localparam int VSW_W  = 4;    // vsync width field
    localparam int LEAP_N = 5;    // leap pattern slots
    localparam int AW     = 4;
    localparam int DW     = 32;

    typedef enum logic [AW-1:0] {
        RA_CTRL   = 4'd0,
        RA_LINE   = 4'd1,
        RA_HPULSE = 4'd2,
        RA_FIELD  = 4'd3,
        RA_LEAP   = 4'd4,
        RA_HWIN   = 4'd5,
        RA_VWIN   = 4'd6,
        RA_VBURST = 4'd7,
        RA_VINT   = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        PT_BLANK = 2'd0,
        PT_RSVD  = 2'd1,
        PT_RGB16 = 2'd2,
        PT_RGB32 = 2'd3
    } pix_type_e;

    typedef struct packed {
        logic [PW-1:0] lo;
        logic [PW-1:0] hi;
    } win_t;

    typedef struct packed {
        pix_type_e          ptype;
        logic               serrate;
        logic [QW-1:0]      line_len;
        logic [HSW_W-1:0]   hs_w;
        logic [BUW_W-1:0]   bu_w;
        logic [PW-1:0]      bu_start;
        logic [VW-1:0]      field_len;
        logic [VSW_W-1:0]   vs_w;
        logic [QW-1:0]      leap_a;
        logic [QW-1:0]      leap_b;
        logic [LEAP_N-1:0]  leap_pat;
    } tcfg_t;

    function automatic logic in_win(input logic [PW-1:0] pos, input win_t w);
        return (pos >= w.lo) && (pos < w.hi);
    endfunction
endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
    import vsg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          load,
    output tcfg_t         shad,
    output win_t          hwin,
    output win_t          vwin,
    output win_t          vbwin,
    output logic [VW-1:0] vint
);
    tcfg_t live_q;
    tcfg_t shad_q;
    logic  unused_bits;

    assign unused_bits = ^wr_data[DW-1:29];

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            shad_q <= '0;
            hwin   <= '0;
            vwin   <= '0;
            vbwin  <= '0;
            vint   <= '1;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    RA_CTRL: begin
                        live_q.ptype   <= pix_type_e'(wr_data[1:0]);
                        live_q.serrate <= wr_data[2];
                    end
                    RA_LINE:   live_q.line_len <= wr_data[QW-1:0];
                    RA_HPULSE: begin
                        live_q.hs_w     <= wr_data[7:0];
                        live_q.bu_w     <= wr_data[15:8];
                        live_q.bu_start <= wr_data[25:16];
                    end
                    RA_FIELD: begin
                        live_q.field_len <= wr_data[9:0];
                        live_q.vs_w      <= wr_data[19:16];
                    end
                    RA_LEAP: begin
                        live_q.leap_a   <= wr_data[11:0];
                        live_q.leap_b   <= wr_data[23:12];
                        live_q.leap_pat <= wr_data[28:24];
                    end
                    RA_HWIN:   hwin  <= '{lo: wr_data[9:0], hi: wr_data[25:16]};
                    RA_VWIN:   vwin  <= '{lo: wr_data[9:0], hi: wr_data[25:16]};
                    RA_VBURST: vbwin <= '{lo: wr_data[9:0], hi: wr_data[25:16]};
                    RA_VINT:   vint  <= wr_data[VW-1:0];
                    default: ;
                endcase
            end
            if (load) shad_q <= live_q;
        end
    end

    assign shad = shad_q;

    // writes never reach the working copy outside a field wrap
    assert_shadow_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load) |=> $stable(shad_q));
endmodule

// File: rtl/vsg_hcount.sv
module vsg_hcount
    import vsg_pkg::*;
#(
    parameter int SLOTS = LEAP_N,
    parameter int CW    = QW
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             in_vs,
    input  logic             field_start,
    input  logic [CW-1:0]    line_len,
    input  logic [CW-1:0]    leap_a,
    input  logic [CW-1:0]    leap_b,
    input  logic [SLOTS-1:0] leap_pat,
    output logic [CW-1:0]    hcnt,
    output logic             line_end
);
    localparam int IW = $clog2(SLOTS);

    logic [CW-1:0] hcnt_q;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cur_len;

    always_comb begin
        cur_len = line_len;
        if (in_vs) cur_len = leap_pat[idx_q] ? leap_b : leap_a;
    end

    assign line_end = adv && (hcnt_q == cur_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q <= '0;
            idx_q  <= '0;
        end else if (adv) begin
            hcnt_q <= line_end ? '0 : hcnt_q + CW'(1);
            if (field_start)
                idx_q <= '0;
            else if (line_end && in_vs)
                idx_q <= (idx_q == IW'(SLOTS - 1)) ? '0 : idx_q + IW'(1);
        end
    end

    assign hcnt = hcnt_q;

    assert_hwrap_R1: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (hcnt_q == '0));
    assert_hhold_R12: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(hcnt_q) && $stable(idx_q)));
    assert_leap_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (line_end && !in_vs && !field_start) |=> $stable(idx_q));
    assert_leap_range_R8: assert property (@(posedge clk) disable iff (rst)
        idx_q < IW'(SLOTS));
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount
    import vsg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic [VW-1:0] field_len,
    input  logic [VW-1:0] vint,
    output logic [VW-1:0] vcnt,
    output logic          field_start,
    output logic          irq
);
    logic [VW-1:0] vcnt_q;
    logic          irq_q;
    logic [VW:0]   nxt;
    logic [VW:0]   lim;
    logic [VW:0]   wrp;
    logic          wrap;
    logic [VW-1:0] vnext;

    always_comb begin
        nxt  = {1'b0, vcnt_q} + (VW+1)'(2);
        lim  = {1'b0, field_len} + (VW+1)'(1);
        wrp  = nxt - lim;
        wrap = nxt > {1'b0, field_len};
        if (wrap)
            vnext = (wrp > {1'b0, field_len}) ? '0 : wrp[VW-1:0];
        else
            vnext = nxt[VW-1:0];
    end

    assign field_start = line_end && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (line_end) vcnt_q <= vnext;
            irq_q <= line_end && (vnext == vint);
        end
    end

    assign vcnt = vcnt_q;
    assign irq  = irq_q;

    assert_vstep_R2: assert property (@(posedge clk) disable iff (rst)
        (line_end && !field_start) |=> (vcnt_q == $past(vcnt_q) + VW'(2)));
    assert_vhold_R12: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(vcnt_q));
    assert_irq_src_R7: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(line_end));
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
    import vsg_pkg::*;
(
    input  logic [QW-1:0]    hcnt,
    input  logic [VW-1:0]    vcnt,
    input  pix_type_e        ptype,
    input  logic             serrate,
    input  logic [HSW_W-1:0] hs_w,
    input  logic [BUW_W-1:0] bu_w,
    input  logic [PW-1:0]    bu_start,
    input  logic [VSW_W-1:0] vs_w,
    input  win_t             hwin,
    input  win_t             vwin,
    input  win_t             vbwin,
    output logic             in_vs,
    output logic             hsync,
    output logic             vsync,
    output logic             burst,
    output logic             active
);
    logic [PW-1:0] pix;
    logic [PW:0]   bu_last;
    logic          on;
    logic          hs_raw;
    logic          bu_h;
    logic          unused_sub;

    assign unused_sub = ^hcnt[1:0];
    assign pix     = hcnt[QW-1:2];
    assign bu_last = {1'b0, bu_start} + {{(PW+1-BUW_W){1'b0}}, bu_w};
    assign on      = (ptype != PT_BLANK);
    assign in_vs   = vcnt <= {{(VW-VSW_W){1'b0}}, vs_w};
    assign hs_raw  = pix <= {{(PW-HSW_W){1'b0}}, hs_w};
    assign bu_h    = (pix >= bu_start) && ({1'b0, pix} <= bu_last);

    always_comb begin
        hsync  = on && ((serrate && in_vs) ? !hs_raw : hs_raw);
        vsync  = on && in_vs;
        burst  = on && bu_h && in_win(vcnt, vbwin);
        active = on && in_win(pix, hwin) && in_win(vcnt, vwin);
    end
endmodule

// File: rtl/vidsync_timer.sv
module vidsync_timer
    import vsg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          qpix_en,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          burst_o,
    output logic          active_o,
    output logic          line_irq_o,
    output logic [VW-1:0] half_line_o,
    output logic          field_o
);
    tcfg_t         shad;
    win_t          hwin;
    win_t          vwin;
    win_t          vbwin;
    logic [VW-1:0] vint;
    logic [QW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          line_end;
    logic          field_start;
    logic          in_vs;

    vsg_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .load(field_start),
        .shad(shad), .hwin(hwin), .vwin(vwin), .vbwin(vbwin), .vint(vint)
    );

    vsg_hcount #(.SLOTS(LEAP_N), .CW(QW)) u_h (
        .clk(clk), .rst(rst), .adv(qpix_en),
        .in_vs(in_vs), .field_start(field_start),
        .line_len(shad.line_len), .leap_a(shad.leap_a), .leap_b(shad.leap_b),
        .leap_pat(shad.leap_pat),
        .hcnt(hcnt), .line_end(line_end)
    );

    vsg_vcount u_v (
        .clk(clk), .rst(rst), .line_end(line_end),
        .field_len(shad.field_len), .vint(vint),
        .vcnt(vcnt), .field_start(field_start), .irq(line_irq_o)
    );

    vsg_decode u_dec (
        .hcnt(hcnt), .vcnt(vcnt),
        .ptype(shad.ptype), .serrate(shad.serrate),
        .hs_w(shad.hs_w), .bu_w(shad.bu_w), .bu_start(shad.bu_start),
        .vs_w(shad.vs_w),
        .hwin(hwin), .vwin(vwin), .vbwin(vbwin),
        .in_vs(in_vs),
        .hsync(hsync_o), .vsync(vsync_o), .burst(burst_o), .active(active_o)
    );

    assign half_line_o = vcnt;
    assign field_o     = vcnt[0];
endmodule

// File: tb/sim_vidsync_timer.sv
module sim_vidsync_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        qpix_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hsync_o, vsync_o, burst_o, active_o, line_irq_o, field_o;
    logic [9:0]  half_line_o;

    always #5 clk = ~clk;

    vidsync_timer u0 (
        .clk(clk), .rst(rst), .qpix_en(qpix_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .burst_o(burst_o),
        .active_o(active_o), .line_irq_o(line_irq_o),
        .half_line_o(half_line_o), .field_o(field_o)
    );

    typedef struct {
        bit hs; bit vs; bit bu; bit ac; bit irq; int hl; bit fld;
    } exp_t;

    exp_t  sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R11 reset";

    // model configuration slots
    localparam int K_TYPE = 0, K_SER = 1, K_LINE = 2, K_HSW = 3, K_BUW = 4,
                   K_BUS = 5, K_FL = 6, K_VSW = 7, K_LA = 8, K_LB = 9, K_PAT = 10;
    int live [0:10];
    int shad [0:10];
    int hw_s = 0, hw_e = 0, vw_s = 0, vw_e = 0, vb_s = 0, vb_e = 0;
    int vint = 1023;
    int m_h = 0, m_v = 0, m_idx = 0;

    task automatic check(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    function automatic exp_t predict(input bit irq);
        exp_t e;
        int  pix  = m_h / 4;
        bit  on   = shad[K_TYPE] != 0;
        bit  invs = m_v <= shad[K_VSW];
        bit  hsr  = pix <= shad[K_HSW];
        e.hs  = on && ((shad[K_SER] != 0 && invs) ? !hsr : hsr);
        e.vs  = on && invs;
        e.bu  = on && pix >= shad[K_BUS] && pix <= shad[K_BUS] + shad[K_BUW]
                   && m_v >= vb_s && m_v < vb_e;
        e.ac  = on && pix >= hw_s && pix < hw_e && m_v >= vw_s && m_v < vw_e;
        e.irq = irq;
        e.hl  = m_v;
        e.fld = (m_v % 2) != 0;
        return e;
    endfunction

    function automatic bit advance();
        bit invs = m_v <= shad[K_VSW];
        int len  = invs ? (((shad[K_PAT] >> m_idx) & 1) != 0 ? shad[K_LB] : shad[K_LA])
                        : shad[K_LINE];
        bit le   = (m_h == len);
        bit fs   = 1'b0;
        int vn   = m_v;
        bit irq;
        if (le) begin
            vn = m_v + 2;
            if (vn > shad[K_FL]) begin
                fs = 1'b1;
                vn = vn - shad[K_FL] - 1;
                if (vn > shad[K_FL]) vn = 0;
            end
        end
        irq = le && (vn == vint);
        m_h = le ? 0 : m_h + 1;
        if (fs) m_idx = 0;
        else if (le && invs) m_idx = (m_idx == 4) ? 0 : m_idx + 1;
        m_v = vn;
        if (fs) shad = live;
        return irq;
    endfunction

    task automatic compare_all(input exp_t e);
        check(int'(hsync_o),    int'(e.hs),  "R3");
        check(int'(vsync_o),    int'(e.vs),  "R4");
        check(int'(burst_o),    int'(e.bu),  "R5");
        check(int'(active_o),   int'(e.ac),  "R6");
        check(int'(line_irq_o), int'(e.irq), "R7");
        check(int'(half_line_o), e.hl,       "R2");
        check(int'(field_o),    int'(e.fld), "R2");
    endtask

    // monitor: pops one expected item per advanced cycle
    always @(negedge clk) begin
        if (sb.size() > 0) compare_all(sb.pop_front());
    end

    // driver: one enabled cycle, expected pushed after the edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            bit irq;
            @(negedge clk);
            qpix_en = 1'b1;
            @(posedge clk);
            irq = advance();
            #1 sb.push_back(predict(irq));
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        qpix_en   = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = 4'(addr);
        cfg_wdata = 32'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            0: begin live[K_TYPE] = data & 3; live[K_SER] = (data >> 2) & 1; end
            1: live[K_LINE] = data & 12'hfff;
            2: begin live[K_HSW] = data & 8'hff; live[K_BUW] = (data >> 8) & 8'hff;
                     live[K_BUS] = (data >> 16) & 10'h3ff; end
            3: begin live[K_FL] = data & 10'h3ff; live[K_VSW] = (data >> 16) & 4'hf; end
            4: begin live[K_LA] = data & 12'hfff; live[K_LB] = (data >> 12) & 12'hfff;
                     live[K_PAT] = (data >> 24) & 5'h1f; end
            5: begin hw_s = data & 10'h3ff; hw_e = (data >> 16) & 10'h3ff; end
            6: begin vw_s = data & 10'h3ff; vw_e = (data >> 16) & 10'h3ff; end
            7: begin vb_s = data & 10'h3ff; vb_e = (data >> 16) & 10'h3ff; end
            8: vint = data & 10'h3ff;
            default: ;
        endcase
    endtask

    // R1: count enabled cycles between two half-line changes
    task automatic measure_line(input int exp_len);
        int prev;
        int cnt = 0;
        bit seen = 1'b0;
        bit fin = 1'b0;
        prev = int'(half_line_o);
        while (!fin) begin
            step(1);
            #1;
            cnt++;
            if (int'(half_line_o) != prev) begin
                if (seen) begin
                    check(cnt, exp_len, "R1 line length");
                    fin = 1'b1;
                end
                seen = 1'b1;
                cnt  = 0;
                prev = int'(half_line_o);
            end
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(1_500_000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (live[i]) begin live[i] = 0; shad[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all(predict(1'b0));             // R11 reset state
        rst = 1'b0;

        phase = "R7 R11 reset interrupt line 0x3FF";
        step(6);

        phase = "R1 R2 R3 R4 R5 R6 progressive";
        wr(0, 32'h2);                            // type 2, no serration
        wr(1, 39);
        wr(2, (3 << 16) | (1 << 8) | 1);
        wr(3, (3 << 16) | 19);                   // 20 half-lines
        wr(4, (0 << 24) | (39 << 12) | 39);
        wr(5, (9 << 16) | 6);
        wr(6, (18 << 16) | 6);
        wr(7, (18 << 16) | 4);
        wr(8, 10);
        step(900);
        measure_line(40);

        phase = "R9 deferred timing, immediate window";
        wr(0, 32'h6);                            // serration on
        wr(1, 31);
        wr(3, (11 << 16) | 20);                  // 21 half-lines -> interlace
        wr(4, (5'b10110 << 24) | (43 << 12) | 35);
        wr(5, (8 << 16) | 5);                    // immediate
        wr(8, 7);                                // immediate
        step(200);

        phase = "R8 R2 interlaced leap lines";
        step(1400);

        phase = "R12 hold";
        repeat (7) begin
            @(negedge clk);
            qpix_en = 1'b0;
        end
        compare_all(predict(1'b0));

        phase = "R10 blanking";
        wr(0, 32'h0);
        step(900);

        @(negedge clk);
        qpix_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule